// File: doc/BRIEF.md
# GPIO Bank with Any-Edge Change Interrupts

This block drives and samples a bank of general-purpose I/O lines through a small word-addressed register interface. Software picks the direction of every line, sets the output values through one data register (optionally limited by a bit mask), and reads the current level of each line back through the same register. Each line feeds a two-stage synchroniser. A change detector then records every transition, rising or falling, in a sticky per-line change bit.

Software masks or unmasks each line for interrupts. The block raises a single registered interrupt whenever any unmasked line has its change bit set. Software acknowledges a line by writing a one to its change bit. The pads take the per-line output value and output enable directly from registers. The bus side is a single-cycle request with a read response one cycle later.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every line is an input (pin_oe all zero), pin_out is zero, the enable and change registers read zero, irq is low, and the write-mask register (byte offset 0x10) reads all ones on the implemented lines.
- R2: Direction register at byte offset 0x00: bit value 1 makes that line an output and 0 an input. pin_oe equals the register from the cycle after the write.
- R3: Data register at byte offset 0x04: a write sets pin_out. A read returns the driven value for output lines and the synchronised pin level for input lines.
- R4: A write to the data register changes only the bits that are set in the write-mask register (byte offset 0x10).
- R5: Any rising or falling transition on a line sets that line's bit in the change register (byte offset 0x0C), once the level has passed the two-flop synchroniser.
- R6: Writing a 1 to a change-register bit clears it. Writing a 0 leaves it unchanged.
- R7: Interrupt-enable register at byte offset 0x08 (1 = unmasked). irq is a register that is high one cycle after any bit is set in both the change register and the enable register.
- R8: When a new edge and a write-one-to-clear hit the same change bit in the same cycle, the bit ends up set.
- R9: The interrupt-type register (byte offset 0x14) always reads all ones on the implemented lines, where 1 means both-edge. Writes to it are ignored.
- R10: Register bits at or above the line count N read as zero and ignore writes. Unmapped offsets read as zero.
- R11: A read request produces exactly one rsp_valid pulse, in the following cycle, carrying the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | N | Line levels from the pads |
| pin_out | output | N | Output values to the pads |
| pin_oe | output | N | Per-line output enables |
| irq | output | 1 | Combined change interrupt, active high |

## Verification
The collision that matters is a fresh edge arriving on a line in the same cycle that software acknowledges that line's change bit. The bench toggles an input whose change bit is already set. It counts the two synchroniser stages and times a write-one-to-clear so that it is sampled on the exact edge where the detector pulses. A later read of the change register must still show the bit set. A second, plain acknowledge must then clear it, which shows that the first acknowledge really landed in that cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    IDX_DIR   = 3'd0,
    IDX_DATA  = 3'd1,
    IDX_IEN   = 3'd2,
    IDX_CHG   = 3'd3,
    IDX_WMASK = 3'd4,
    IDX_TYPE  = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int N      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] level,
  output logic [N-1:0] edge_hit
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stg[s] <= '0;
        end else if (s == 0) begin
          stg[s] <= pin_in;
        end else begin
          stg[s] <= stg[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[STAGES-1];
  end

  assign level    = stg[STAGES-1];
  assign edge_hit = stg[STAGES-1] ^ prev_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int N = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [N-1:0]     wr_data,
  output logic [N-1:0]     dir_q,
  output logic [N-1:0]     out_q,
  output logic [N-1:0]     ien_q,
  output logic [N-1:0]     wmask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      wmask_q <= '1;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_DIR:   dir_q   <= wr_data;
        IDX_DATA:  out_q   <= (out_q & ~wmask_q) | (wr_data & wmask_q);
        IDX_IEN:   ien_q   <= wr_data;
        IDX_WMASK: wmask_q <= wr_data;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_change.sv
module gpio_change #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] edge_hit,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] ien,
  output logic [N-1:0] chg_q,
  output logic         irq_q
);
  logic [N-1:0] clr_eff;

  always_comb begin
    clr_eff = clr_en ? clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      chg_q <= (chg_q & ~clr_eff) | edge_hit;
      irq_q <= |(chg_q & ien);
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N      = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0]  word_sel;
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic             wr_en;
  logic             rd_en;
  logic [N-1:0]     wdata_n;
  logic [N-1:0]     dir_q, out_q, ien_q, wmask_q, chg_q;
  logic [N-1:0]     level_w, edge_w, rd_lines;
  logic [31:0]      rd_word;

  assign word_sel = req_addr[ADDR_W-1:2];
  assign idx      = word_sel[IDX_W-1:0];
  assign hit      = (req_addr[1:0] == 2'b00) && (word_sel < HI_W'(6));
  assign wr_en    = req_valid && req_write && hit;
  assign rd_en    = req_valid && !req_write;
  assign wdata_n  = req_wdata[N-1:0];

  gpio_sync_edge #(.N(N), .STAGES(2)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .level    (level_w),
    .edge_hit (edge_w)
  );

  gpio_regs #(.N(N)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (wdata_n),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .ien_q   (ien_q),
    .wmask_q (wmask_q)
  );

  gpio_change #(.N(N)) chg_i (
    .clk      (clk),
    .rst      (rst),
    .edge_hit (edge_w),
    .clr_en   (wr_en && (idx == IDX_CHG)),
    .clr_bits (wdata_n),
    .ien      (ien_q),
    .chg_q    (chg_q),
    .irq_q    (irq)
  );

  always_comb begin
    rd_lines = '0;
    if (hit) begin
      case (idx)
        IDX_DIR:   rd_lines = dir_q;
        IDX_DATA:  rd_lines = (dir_q & out_q) | (~dir_q & level_w);
        IDX_IEN:   rd_lines = ien_q;
        IDX_CHG:   rd_lines = chg_q;
        IDX_WMASK: rd_lines = wmask_q;
        IDX_TYPE:  rd_lines = '1;
        default:   rd_lines = '0;
      endcase
    end
    rd_word        = '0;
    rd_word[N-1:0] = rd_lines;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_word;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N      = 24,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic [N-1:0]      pin_oe,
  input logic              irq,
  input logic [N-1:0]      chg,
  input logic [N-1:0]      ien,
  input logic [N-1:0]      edge_hit
);
  logic [31:0] line_mask;
  always_comb begin
    line_mask        = '0;
    line_mask[N-1:0] = '1;
  end

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == ADDR_W'(8'h00)) |=> (pin_oe == $past(req_wdata[N-1:0]))); // R2

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == ADDR_W'(8'h0C))
      |=> ((chg & $past(req_wdata[N-1:0]) & ~$past(edge_hit)) == '0)); // R6

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(chg & ien))); // R7

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (|edge_hit) |=> ((chg & $past(edge_hit)) == $past(edge_hit))); // R8

  AST_TYPE_CONST: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_addr) == ADDR_W'(8'h14)) |-> (rsp_rdata == line_mask)); // R9

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid); // R11

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid); // R11
endmodule

bind gpio_bank gpio_bank_chk #(.N(N), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .chg       (chg_q),
  .ien       (ien_q),
  .edge_hit  (edge_w)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam int ADDR_W = 5;
  localparam logic [31:0] LMASK = 32'h00FF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank #(.N(N), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a[ADDR_W-1:0]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a[ADDR_W-1:0];
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop expected read data as responses appear (R11)
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 actual=%08h expected=no response", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(8'h00, 32'h0, "R1 dir");
    rd(8'h04, 32'h0, "R1 data");
    rd(8'h08, 32'h0, "R1 ien");
    rd(8'h0C, 32'h0, "R1 chg");
    rd(8'h10, LMASK, "R1 wmask");
    rd(8'h14, LMASK, "R9 type");
    // R2 / R10 direction
    wr(8'h00, 32'hFFFF_00FF);
    check("R2 pin_oe", 32'(pin_oe), 32'h00FF_00FF);
    rd(8'h00, 32'h00FF_00FF, "R10 dir upper bits");
    // R3 data
    wr(8'h04, 32'hFFFF_FFFF);
    check("R3 pin_out", 32'(pin_out), LMASK);
    rd(8'h04, 32'h00FF_00FF, "R3 data readback");
    @(negedge clk); pin_in = 24'h00_A500;
    idle(4);
    rd(8'h04, 32'h00FF_A5FF, "R3 input level");
    // R4 write mask
    wr(8'h10, 32'h0000_000F);
    wr(8'h04, 32'h0);
    check("R4 masked write", 32'(pin_out), 32'h00FF_FFF0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, LMASK, "R10 wmask upper bits");
    // R5 rising edges
    rd(8'h0C, 32'h0000_A500, "R5 rising");
    check("R7 irq masked", 32'(irq), 32'h0);
    // R6 clear
    wr(8'h0C, 32'h0000_0500);
    rd(8'h0C, 32'h0000_A000, "R6 w1c");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h0000_A000, "R6 write zero");
    // R7 interrupt
    wr(8'h08, 32'h0000_2000);
    idle(1);
    check("R7 irq on", 32'(irq), 32'h1);
    wr(8'h08, 32'h0000_0001);
    idle(1);
    check("R7 irq masked off", 32'(irq), 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R6 clear all");
    // R5 falling edge
    @(negedge clk); pin_in[13] = 1'b0;
    idle(4);
    rd(8'h0C, 32'h0000_2000, "R5 falling");
    wr(8'h08, 32'h0000_2000);
    idle(1);
    check("R7 irq falling", 32'(irq), 32'h1);
    wr(8'h0C, 32'h0000_2000);
    idle(1);
    check("R7 irq after ack", 32'(irq), 32'h0);
    // R8 edge beats clear in the same cycle
    @(negedge clk); pin_in[8] = 1'b0;
    idle(4);
    rd(8'h0C, 32'h0000_0100, "R8 setup");
    @(negedge clk); pin_in[8] = 1'b1;
    @(negedge clk);
    wr(8'h0C, 32'h0000_0100);
    rd(8'h0C, 32'h0000_0100, "R8 edge wins");
    wr(8'h0C, 32'h0000_0100);
    rd(8'h0C, 32'h0, "R8 later ack");
    // R9 / R10 constants
    wr(8'h14, 32'h0);
    rd(8'h14, LMASK, "R9 type after write");
    rd(8'h18, 32'h0, "R10 unmapped");
    idle(3);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11 actual=%0d pending expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule